// File: doc/BRIEF.md
# Serial-Chain Configuration Loader with Default Override

This block gives a control map of nine 8-bit registers a second way in besides the usual host bus: a plain bit-serial load. When the mode pin and the power-down pin are both high, every active register bit becomes one stage of a single shift chain. Each falling edge of the serial clock moves the chain one place and takes the serial data pin into the first stage. The last stage is always driven onto the voice-activity control pin, so the old contents leave the chain as new ones arrive. The host-bus protocol logic sits outside this block.

The mode pin also selects which map the rest of the chip sees. While it is high, the effective map is a fixed default pattern. In that pattern the power-down bit follows the inverted power-down pin, and the tone generator is held off. When the mode pin goes low, the loaded chain contents become the effective map. The serial clock, serial data and both mode pins are asynchronous. Each passes through a synchronizer, and clock edges are found in the system clock domain. The chain registers have no reset, so the first full chain length of bits shifted out is undefined.

The serial load has no valid/ready handshake and cannot push back. A bit is taken on each qualified falling edge. Each phase of the serial clock must therefore last longer than the synchronizer depth plus one system clock cycle.

Top module: `cfgchain_loader`

## Requirements
- R1: The chain shifts only on a falling edge of the serial clock, and only while both the mode pin and the power-down pin are high. With either pin low, serial clock edges leave the contents unchanged.
- R2: On each shift, the first stage (register 0 bit 0) takes the serial data value, and every other active bit takes the value of the active bit before it in chain order.
- R3: Bits 6 and 7 of registers 0 and 1 are not part of the chain. Register 0 bit 5 feeds register 1 bit 0, register 1 bit 5 feeds register 2 bit 0, and in the later registers bit 7 feeds bit 0 of the next register. With the mode pin low, the skipped bits read 0 in the effective map.
- R4: The chain has 68 stages. A bit entered at the first stage reaches register 8 bit 7 after exactly 68 shifts. The voice-activity output always shows register 8 bit 7.
- R5: While the mode pin is high, the effective map (flat bit index = register*8 + bit) is all zeros except bits 0, 1 and 10, which read 1. Bit 50 (register 6 bit 2, power-down) reads the inverse of the power-down pin.
- R6: The tone-enable output is low while the mode pin is high and high while it is low.
- R7: While the mode pin is low, the effective map equals the chain contents in place, and rising serial clock edges never shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset for synchronizers and edge detector |
| dft_i | input | 1 | Default-mode pin, asynchronous |
| hpdn_i | input | 1 | Power-down pin, asynchronous |
| scl_i | input | 1 | Serial shift clock, asynchronous |
| sda_i | input | 1 | Serial data, asynchronous |
| cfg_o | output | 72 | Effective control map, flat index register*8 + bit |
| tone_en_o | output | 1 | Tone generator allowed |
| vox_o | output | 1 | Chain tail (register 8 bit 7) |

## Verification
The bench builds the block with its default parameters: nine registers, two short registers of six active bits, a 68-stage chain and a two-flop synchronizer. These make the full-length walk of a single 1 from the first stage to the tail observable. They also bring within reach the exact 67-versus-68 shift boundary and the splice points at register 0 bit 5 and register 1 bit 5. Random 68-bit loads, partial shifts and gated serial clock pulses are compared against a bench-side chain model. Each load is read back by dropping the mode pin.

// File: rtl/cfgchain_pkg.sv
package cfgchain_pkg;

  // Active bits of register r: short registers drop their top bits.
  function automatic int act_width(input int r, input int short_regs,
                                   input int short_w, input int reg_w);
    return (r < short_regs) ? short_w : reg_w;
  endfunction

  // Position of register r, bit b in the chain (0 = entry stage).
  function automatic int chain_index(input int r, input int b, input int short_regs,
                                     input int short_w, input int reg_w);
    if (r < short_regs)
      return r * short_w + b;
    return short_regs * short_w + (r - short_regs) * reg_w + b;
  endfunction

  function automatic int chain_length(input int num_regs, input int short_regs,
                                      input int short_w, input int reg_w);
    return short_regs * short_w + (num_regs - short_regs) * reg_w;
  endfunction

endpackage

// File: rtl/cfgchain_sync.sv
module cfgchain_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg_q[0] <= RESET_VAL;
          else        stg_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg_q[s] <= RESET_VAL;
          else        stg_q[s] <= stg_q[s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfgchain_edge.sv
module cfgchain_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic dft_s,
  input  logic hpdn_s,
  output logic shift_en_o
);
  logic scl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_s;

  assign shift_en_o = scl_q & ~scl_s & dft_s & hpdn_s;
endmodule

// File: rtl/cfgchain_shift.sv
module cfgchain_shift
  import cfgchain_pkg::*;
#(
  parameter int NUM_REGS   = 9,
  parameter int REG_W      = 8,
  parameter int SHORT_REGS = 2,
  parameter int SHORT_W    = 6,
  localparam int CHAIN_LEN = chain_length(NUM_REGS, SHORT_REGS, SHORT_W, REG_W),
  localparam int MAP_W     = NUM_REGS * REG_W
) (
  input  logic                 clk,
  input  logic                 shift_en,
  input  logic                 sda_s,
  output logic [CHAIN_LEN-1:0] chain_o,
  output logic [MAP_W-1:0]     map_o
);
  logic [CHAIN_LEN-1:0] chain_q;

  // No reset: contents are undefined until a full load.
  always_ff @(posedge clk)
    if (shift_en) chain_q <= {chain_q[CHAIN_LEN-2:0], sda_s};

  assign chain_o = chain_q;

  genvar r, b;
  generate
    for (r = 0; r < NUM_REGS; r++) begin : g_reg
      for (b = 0; b < REG_W; b++) begin : g_bit
        if (b < act_width(r, SHORT_REGS, SHORT_W, REG_W)) begin : g_act
          localparam int IDX = chain_index(r, b, SHORT_REGS, SHORT_W, REG_W);
          assign map_o[r*REG_W + b] = chain_q[IDX];
        end else begin : g_skip
          assign map_o[r*REG_W + b] = 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cfgchain_override.sv
module cfgchain_override #(
  parameter int MAP_W = 72,
  parameter int PWDN_IDX = 50,
  parameter logic [MAP_W-1:0] DEFAULT_MAP = '0
) (
  input  logic             dft_s,
  input  logic             hpdn_s,
  input  logic [MAP_W-1:0] map_i,
  output logic [MAP_W-1:0] cfg_o,
  output logic             tone_en_o
);
  logic [MAP_W-1:0] dflt;

  always_comb begin
    dflt = DEFAULT_MAP;
    dflt[PWDN_IDX] = ~hpdn_s;
    cfg_o = dft_s ? dflt : map_i;
  end

  assign tone_en_o = ~dft_s;
endmodule

// File: rtl/cfgchain_loader.sv
module cfgchain_loader
  import cfgchain_pkg::*;
#(
  parameter int NUM_REGS    = 9,
  parameter int REG_W       = 8,
  parameter int SHORT_REGS  = 2,
  parameter int SHORT_W     = 6,
  parameter int SYNC_STAGES = 2,
  parameter int PWDN_REG    = 6,
  parameter int PWDN_BIT    = 2,
  parameter logic [NUM_REGS*REG_W-1:0] DEFAULT_MAP = 'h403,
  localparam int MAP_W      = NUM_REGS * REG_W,
  localparam int CHAIN_LEN  = chain_length(NUM_REGS, SHORT_REGS, SHORT_W, REG_W),
  localparam int PWDN_IDX   = PWDN_REG * REG_W + PWDN_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dft_i,
  input  logic             hpdn_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic [MAP_W-1:0] cfg_o,
  output logic             tone_en_o,
  output logic             vox_o
);
  logic dft_s, hpdn_s, scl_s, sda_s;
  logic shift_en;
  logic [CHAIN_LEN-1:0] chain_q;
  logic [MAP_W-1:0] map_q;

  // Reset values: defaults on, powered down, serial bus idle.
  cfgchain_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_dft
    (.clk(clk), .rst_n(rst_n), .d_i(dft_i),  .q_o(dft_s));
  cfgchain_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_hpdn
    (.clk(clk), .rst_n(rst_n), .d_i(hpdn_i), .q_o(hpdn_s));
  cfgchain_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl
    (.clk(clk), .rst_n(rst_n), .d_i(scl_i),  .q_o(scl_s));
  cfgchain_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda
    (.clk(clk), .rst_n(rst_n), .d_i(sda_i),  .q_o(sda_s));

  cfgchain_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .dft_s(dft_s),
    .hpdn_s(hpdn_s), .shift_en_o(shift_en)
  );

  cfgchain_shift #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .SHORT_REGS(SHORT_REGS), .SHORT_W(SHORT_W)
  ) u_shift (
    .clk(clk), .shift_en(shift_en), .sda_s(sda_s), .chain_o(chain_q), .map_o(map_q)
  );

  cfgchain_override #(
    .MAP_W(MAP_W), .PWDN_IDX(PWDN_IDX), .DEFAULT_MAP(DEFAULT_MAP)
  ) u_ovr (
    .dft_s(dft_s), .hpdn_s(hpdn_s), .map_i(map_q), .cfg_o(cfg_o), .tone_en_o(tone_en_o)
  );

  assign vox_o = chain_q[CHAIN_LEN-1];
endmodule

// File: rtl/cfgchain_chk.sv
module cfgchain_chk
  import cfgchain_pkg::*;
#(
  parameter int NUM_REGS   = 9,
  parameter int REG_W      = 8,
  parameter int SHORT_REGS = 2,
  parameter int SHORT_W    = 6,
  parameter int CHAIN_LEN  = 68,
  parameter int PWDN_IDX   = 50
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    shift_en,
  input logic                    sda_s,
  input logic                    dft_s,
  input logic                    hpdn_s,
  input logic [CHAIN_LEN-1:0]    chain_q,
  input logic [NUM_REGS*REG_W-1:0] cfg_o,
  input logic                    tone_en_o,
  input logic                    vox_o
);
  logic [NUM_REGS*REG_W-1:0] skip_m;

  always_comb
    for (int r = 0; r < NUM_REGS; r++)
      for (int b = 0; b < REG_W; b++)
        skip_m[r*REG_W + b] = (b >= act_width(r, SHORT_REGS, SHORT_W, REG_W));

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(chain_q));

  // R1
  shift_needs_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (dft_s && hpdn_s));

  // R2
  entry_takes_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> chain_q[0] == $past(sda_s));

  // R4
  tail_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> vox_o == $past(chain_q[CHAIN_LEN-2]));

  // R3
  skipped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dft_s |-> (cfg_o & skip_m) == '0);

  // R5
  pwdn_follows_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dft_s |-> cfg_o[PWDN_IDX] != hpdn_s);

  // R6
  tone_off_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dft_s |-> !tone_en_o);
endmodule

bind cfgchain_loader cfgchain_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .SHORT_REGS(SHORT_REGS), .SHORT_W(SHORT_W),
  .CHAIN_LEN(CHAIN_LEN), .PWDN_IDX(PWDN_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sda_s(sda_s), .dft_s(dft_s),
  .hpdn_s(hpdn_s), .chain_q(chain_q), .cfg_o(cfg_o), .tone_en_o(tone_en_o), .vox_o(vox_o)
);

// File: tb/test_cfgchain_loader.sv
module test_cfgchain_loader;
  localparam int N = 68;

  logic clk = 1'b0;
  logic rst_n, dft, hpdn, scl, sda;
  logic [71:0] cfg;
  logic tone_en, vox;

  int checks = 0;
  int errors = 0;
  bit model [N];

  always #2 clk = ~clk;

  cfgchain_loader i_cfgchain_loader (
    .clk(clk), .rst_n(rst_n), .dft_i(dft), .hpdn_i(hpdn), .scl_i(scl), .sda_i(sda),
    .cfg_o(cfg), .tone_en_o(tone_en), .vox_o(vox)
  );

  function automatic logic [71:0] exp_map();
    logic [71:0] m = '0;
    for (int i = 0; i < N; i++) begin
      int pos = (i < 12) ? (i / 6) * 8 + (i % 6) : i + 4;
      m[pos] = model[i];
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit b);
    @(negedge clk);
    sda = b;
    wait_cyc(4);
    scl = 1'b0;
    wait_cyc(5);
    scl = 1'b1;
    wait_cyc(5);
    if (dft && hpdn) begin
      for (int i = N - 1; i > 0; i--) model[i] = model[i-1];
      model[0] = b;
    end
  endtask

  task automatic set_pins(input bit d, input bit h);
    @(negedge clk);
    dft = d;
    hpdn = h;
    wait_cyc(6);
  endtask

  // Load n random bits, checking the tail after every shift (R4).
  task automatic load_random(input int n);
    for (int k = 0; k < n; k++) begin
      pulse(1'($urandom()));
      check("R4 tail", {71'd0, vox}, {71'd0, model[N-1]});
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; dft = 1'b1; hpdn = 1'b1; scl = 1'b1; sda = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(6);

    // R5 R6: defaults at reset with power-down pin high and low.
    check("R5 default map", cfg, 72'h403);
    check("R6 tone off", {71'd0, tone_en}, 72'd0);
    set_pins(1'b1, 1'b0);
    check("R5 pwdn inverse", cfg, 72'h403 | (72'd1 << 50));
    set_pins(1'b1, 1'b1);

    // R4: walk a single 1 through a cleared chain.
    for (int k = 0; k < N; k++) pulse(1'b0);
    pulse(1'b1);
    for (int k = 0; k < N - 2; k++) pulse(1'b0);
    check("R4 after 67 shifts", {71'd0, vox}, 72'd0);
    pulse(1'b0);
    check("R4 after 68 shifts", {71'd0, vox}, 72'd1);
    set_pins(1'b0, 1'b1);
    check("R7 walked one", cfg, 72'd1 << 71);
    check("R6 tone on", {71'd0, tone_en}, 72'd1);

    // R3: splice points at register 0 bit 5 and register 1 bit 5.
    set_pins(1'b1, 1'b1);
    for (int k = 0; k < N; k++) pulse(1'b1);
    set_pins(1'b0, 1'b1);
    check("R3 skipped bits zero", cfg & 72'hC0C0, 72'h0);
    check("R3 full ones map", cfg, exp_map());
    set_pins(1'b1, 1'b1);
    pulse(1'b0); pulse(1'b0); pulse(1'b0); pulse(1'b0); pulse(1'b0); pulse(1'b0);
    pulse(1'b0);
    set_pins(1'b0, 1'b1);
    check("R3 R0B5 into R1B0", cfg[15:0], 16'h3E00);

    // R2 R7: random full and partial loads.
    for (int round = 0; round < 4; round++) begin
      set_pins(1'b1, 1'b1);
      load_random((round % 2 == 0) ? N : 5 + int'($urandom_range(20)));
      set_pins(1'b0, 1'b1);
      check("R2 R7 loaded map", cfg, exp_map());
    end

    // R7: serial clock with mode pin low does nothing.
    for (int k = 0; k < 10; k++) pulse(1'($urandom()));
    check("R7 no shift mode low", cfg, exp_map());
    set_pins(1'b0, 1'b0);
    for (int k = 0; k < 6; k++) pulse(1'($urandom()));
    check("R7 no shift both low", cfg, exp_map());

    // R1: mode pin high but power-down pin low blocks shifting.
    set_pins(1'b1, 1'b0);
    for (int k = 0; k < 10; k++) pulse(~model[0]);
    check("R1 pwdn blocks", cfg, 72'h403 | (72'd1 << 50));
    set_pins(1'b0, 1'b1);
    check("R1 contents kept", cfg, exp_map());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule